// File: doc/BRIEF.md
# Register-pair load/store timing sequencer

This block sequences an instruction that loads or stores a pair of registers. It takes one decoded request and from it produces three things: an issue-stall signal that lasts for as many cycles as the instruction occupies issue, one or two doubleword memory beats, and single-cycle strobes that mark when each result is ready. The stall length depends on the addressing mode. Pre-indexed addressing with a subtracted register offset issues over three cycles, and every other mode issues in one. The number of memory beats depends on whether the address is doubleword aligned.

A request is captured on the clock edge where `req_valid` is high and `busy` is low. The first cycle in which `busy` is high is issue cycle 0, and every latency below counts from that cycle. The block accepts no other request until the whole sequence is over. Let I be the number of issue cycles (1 or 3). Beat 0 is presented in cycle I-1, and an unaligned access adds beat 1 in cycle I. A beat that is not accepted holds, and the whole timeline waits with it. The timing figures below assume memory accepts each beat in the cycle it is presented.

Top module: `pair_ldst_seq`

## Requirements
- R1: With `req_neg_ofs`=0, the issue occupancy T is 1 cycle for an aligned access without writeback and 2 cycles otherwise. `issue_stall` is high in cycles 0..T-2.
- R2: With `req_neg_ofs`=1 (pre-indexed, subtracted register offset), I=3. T is 3 for an aligned access without writeback and 4 otherwise. `issue_stall` is high in cycles 0..T-2.
- R3: An address whose low 3 bits are zero produces exactly one beat, in cycle I-1, at that address. Any other address produces two beats. Beat 0 comes in cycle I-1 at the address with its low 3 bits cleared, and beat 1 comes in cycle I at that address plus 8, wrapping at the top of the address space.
- R4: Writeback adds one issue cycle only when the access is aligned. For an unaligned access T=I+1 whether writeback is set or not.
- R5: For an aligned load, `rt_ready` and `rt2_ready` both pulse for one cycle in cycle I+1.
- R6: For an unaligned load, `rt_ready` pulses in cycle I+1 and `rt2_ready` pulses in cycle I+2.
- R7: `base_ready` pulses for one cycle in cycle I+1 when writeback is requested, whatever the alignment. It never pulses without writeback.
- R8: While `mem_valid` is high and `mem_ready` is low, the beat and its address hold and the whole timeline waits.
- R9: While `busy` is high, `req_valid` is ignored and the sequence in progress is not disturbed. `busy` falls after the last event of the sequence.
- R10: A synchronous reset returns the block to idle: `busy`, `issue_stall`, `mem_valid` and all strobes are low.
- R11: `mem_write` is high on the beats of a store. A store raises neither `rt_ready` nor `rt2_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_neg_ofs | input | 1 | 1: pre-indexed with subtracted register offset (three issue cycles) |
| req_load | input | 1 | 1: load, 0: store |
| req_wb | input | 1 | Base writeback requested |
| req_addr | input | AW | Effective byte address |
| busy | output | 1 | Sequence in progress; requests are ignored |
| issue_stall | output | 1 | Issue stage held by this instruction |
| mem_valid | output | 1 | Memory beat presented |
| mem_write | output | 1 | Beat is a store |
| mem_addr | output | AW | Doubleword-aligned beat address |
| mem_ready | input | 1 | Memory accepts the beat |
| rt_ready | output | 1 | First data register ready (pulse) |
| rt2_ready | output | 1 | Second data register ready (pulse) |
| base_ready | output | 1 | Updated base register ready (pulse) |

## Verification
Each combination of addressing mode, writeback, alignment and direction is run once with memory always ready. These runs separate R1 from R2 by stall length, separate writeback from misalignment as the cause of the extra cycle, and separate the aligned strobe timing from the staggered one. Random requests are then run with random `mem_ready` back-pressure, which shows whether the timeline freezes on a refused beat or slips past it. During each sequence a differing request is held on the inputs, so any corruption of the sequence in progress would show up. An address in the last doubleword checks the wrap of the second beat, and a reset in mid-sequence checks the return to idle.

// File: rtl/pair_ldst_seq.sv
module pair_ldst_seq #(
  parameter int AW = 32,
  parameter int BEAT_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_neg_ofs,
  input  logic          req_load,
  input  logic          req_wb,
  input  logic [AW-1:0] req_addr,
  output logic          busy,
  output logic          issue_stall,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ready,
  output logic          rt_ready,
  output logic          rt2_ready,
  output logic          base_ready
);
  localparam int OFS = $clog2(BEAT_BYTES);
  localparam int LW  = AW - OFS;

  logic          busy_q, neg_q, load_q, wb_q, unal_q;
  logic [LW-1:0] line_q;
  logic [2:0]    cyc;
  logic [2:0]    last_iss, stall_end, strobe_c, end_c;
  logic          beat1, freeze;

  assign last_iss  = neg_q ? 3'd2 : 3'd0;
  assign stall_end = last_iss + {2'b0, unal_q | wb_q};
  assign strobe_c  = last_iss + 3'd2;
  assign end_c     = (load_q | wb_q) ? strobe_c + {2'b0, load_q & unal_q}
                                     : last_iss + {2'b0, unal_q};

  assign beat1       = unal_q && cyc == last_iss + 3'd1;
  assign busy        = busy_q;
  assign issue_stall = busy_q && cyc < stall_end;
  assign mem_valid   = busy_q && (cyc == last_iss || beat1);
  assign mem_write   = !load_q;
  assign mem_addr    = {line_q + {{(LW-1){1'b0}}, beat1}, {OFS{1'b0}}};
  assign freeze      = mem_valid && !mem_ready;

  assign rt_ready   = busy_q && load_q && cyc == strobe_c;
  assign rt2_ready  = busy_q && load_q && cyc == strobe_c + {2'b0, unal_q};
  assign base_ready = busy_q && wb_q && cyc == strobe_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      neg_q  <= 1'b0;
      load_q <= 1'b0;
      wb_q   <= 1'b0;
      unal_q <= 1'b0;
      line_q <= '0;
      cyc    <= '0;
    end else if (!busy_q) begin
      if (req_valid) begin
        busy_q <= 1'b1;
        neg_q  <= req_neg_ofs;
        load_q <= req_load;
        wb_q   <= req_wb;
        unal_q <= |req_addr[OFS-1:0];
        line_q <= req_addr[AW-1:OFS];
        cyc    <= '0;
      end
    end else if (!freeze) begin
      if (cyc == end_c) busy_q <= 1'b0;
      else              cyc    <= cyc + 3'd1;
    end
  end

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)); // R8
  AST_RT_PULSE: assert property (@(posedge clk) disable iff (rst)
    rt_ready |=> !rt_ready); // R5
  AST_RT2_STAGGER: assert property (@(posedge clk) disable iff (rst)
    rt2_ready && !rt_ready |-> $past(rt_ready)); // R6
  AST_BASE_NEEDS_WB: assert property (@(posedge clk) disable iff (rst)
    base_ready |-> wb_q); // R7
  AST_STORE_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    mem_valid && mem_write |-> !rt_ready && !rt2_ready); // R11
  AST_STALL_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    issue_stall |-> busy); // R9
  AST_IDLE_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !busy && !mem_valid); // R10
endmodule

// File: tb/sim_pair_ldst_seq.sv
module sim_pair_ldst_seq;
  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_neg_ofs = 1'b0, req_load = 1'b0, req_wb = 1'b0;
  logic [31:0] req_addr = '0;
  logic busy, issue_stall, mem_valid, mem_write, mem_ready = 1'b1;
  logic [31:0] mem_addr;
  logic rt_ready, rt2_ready, base_ready;
  int checks = 0, fails = 0, wd = 0;

  always #5 clk = ~clk;

  pair_ldst_seq u0 (.clk, .rst, .req_valid, .req_neg_ofs, .req_load, .req_wb, .req_addr,
    .busy, .issue_stall, .mem_valid, .mem_write, .mem_addr, .mem_ready,
    .rt_ready, .rt2_ready, .base_ready);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int n_iss(bit neg); return neg ? 3 : 1; endfunction
  function automatic int occ(bit neg, bit wb, bit un); return n_iss(neg) + ((un || wb) ? 1 : 0); endfunction
  function automatic int last_ev(bit neg, bit ld, bit wb, bit un);
    if (ld || wb) return n_iss(neg) + 1 + ((ld && un) ? 1 : 0);
    return n_iss(neg) - 1 + (un ? 1 : 0);
  endfunction

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", wd, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run_one(input bit neg, input bit ld, input bit wb, input logic [31:0] a, input bit rnd_ready);
    bit un = |a[2:0];
    int e = 0, ii = n_iss(neg), t = occ(neg, wb, un), le = last_ev(neg, ld, wb, un);
    bit mv;
    logic [31:0] ea;
    chk("R9 idle before request", {31'b0, busy}, 0);
    req_valid = 1; req_neg_ofs = neg; req_load = ld; req_wb = wb; req_addr = a;
    @(negedge clk);
    req_neg_ofs = ~neg; req_load = ~ld; req_wb = ~wb; req_addr = a ^ 32'h0000_0105;
    while (e <= le) begin
      mem_ready = rnd_ready ? ($urandom_range(0, 2) != 0) : 1'b1;
      mv = (e == ii - 1) || (un && e == ii);
      ea = {a[31:3], 3'b0} + ((un && e == ii) ? 32'd8 : 32'd0);
      chk("R9 busy during sequence", {31'b0, busy}, 1);
      chk(neg ? "R2 R4 issue_stall" : "R1 R4 issue_stall", {31'b0, issue_stall}, {31'b0, e < t - 1});
      chk("R3 mem_valid", {31'b0, mem_valid}, {31'b0, mv});
      if (mv) begin
        chk("R3 mem_addr", mem_addr, ea);
        chk("R11 mem_write", {31'b0, mem_write}, {31'b0, !ld});
      end
      chk(un ? "R6 rt_ready" : "R5 rt_ready", {31'b0, rt_ready}, {31'b0, ld && e == ii + 1});
      chk(un ? "R6 rt2_ready" : "R5 rt2_ready", {31'b0, rt2_ready}, {31'b0, ld && e == ii + 1 + (un ? 1 : 0)});
      chk("R7 base_ready", {31'b0, base_ready}, {31'b0, wb && e == ii + 1});
      if (mv && !mem_ready) chk("R8 no strobe while held", {29'b0, rt_ready, rt2_ready, base_ready}, 0);
      else e++;
      @(negedge clk);
    end
    req_valid = 0;
    chk("R9 busy falls after last event", {31'b0, busy}, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R10 reset busy", {31'b0, busy}, 0);
    chk("R10 reset outputs", {27'b0, issue_stall, mem_valid, rt_ready, rt2_ready, base_ready}, 0);
    for (int k = 0; k < 16; k++)
      run_one(k[0], k[1], k[2], k[3] ? 32'h0000_1234 : 32'h0000_1238, 0);
    run_one(0, 1, 1, 32'hFFFF_FFFC, 0);
    run_one(1, 0, 0, 32'hFFFF_FFF9, 1);
    for (int k = 0; k < 150; k++)
      run_one($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
              ($urandom_range(0, 1) != 0) ? ($urandom & 32'hFFFF_FFF8) : $urandom, 1);
    req_valid = 1; req_neg_ofs = 1; req_load = 1; req_wb = 1; req_addr = 32'h10;
    @(negedge clk); @(negedge clk);
    rst = 1; req_valid = 0;
    @(negedge clk);
    rst = 0;
    chk("R10 mid-sequence reset busy", {31'b0, busy}, 0);
    chk("R10 mid-sequence reset outputs", {27'b0, issue_stall, mem_valid, rt_ready, rt2_ready, base_ready}, 0);
    run_one(0, 1, 0, 32'h0000_0040, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule